// File: doc/BRIEF.md
# Boot memory map initializer

This sequencer runs once, when start_i is pulsed after reset. It works out which physical pages respond correctly and builds a table that maps virtual pages to real pages. It then zeroes every page it mapped, and finally zeroes the low bank except for its first two pages. All of its memory traffic goes through one synchronous port. The port carries a bank number and an in-bank word offset, and it allows one request at a time. A request is held until the memory returns an acknowledge, together with read data and a double-bit-error flag.

The sequence has five passes:
- **Tagging.** Every installed page, from the highest page down to page 0, gets its own global page number written into its first word. Because the walk goes downward, a lower page that aliases a higher one overwrites it and wins.
- **Vacating.** Every map-table entry at the start of bank 1 is set to a vacant code.
- **Scan.** Pages are checked upward from a chosen page of bank 1. Each page whose tag reads back intact is packed into the next free virtual slot.
- **Clearing.** Each mapped page is zeroed, walking the map table slot by slot.
- **Low bank.** Bank 0 is zeroed from page 2 up to its end.

A double-bit error during the scan only skips that page. The same error while reading the map table in the clearing pass halts the block for good. When the passes finish, done_o pulses for one cycle and the number of mapped pages stays on page_cnt_o.

Top module: `boot_map_init`

## Requirements
- R1: After reset, done_o, fatal_o and mem_req_o are 0 and page_cnt_o is 0. The block makes no memory request until start_i is seen high.
- R2: Global page number p means bank p div PPB, page p mod PPB, where PPB = 2^(OFS_W-PAGE_W). Pages are tagged from BANK_CNT*PPB-1 down to 0, and each page's word 0 receives p. When two pages alias, the lower-numbered page's tag is the one left in storage.
- R3: All MAP_PAGES*2^PAGE_W map entries are written with VACANT. The map table sits at bank 1, offsets 0 and up. Slots that receive no mapping still hold VACANT at the end.
- R4: The scan starts at page IO_PAGE of bank 1 and steps up one page at a time, crossing bank boundaries. It stops after the last page of bank STOP_BANK-1. Each page whose word 0 equals its own number produces the entry (page_in_bank << PAGE_W) | bank | PRESENT. The entry is written at the next slot, starting at slot 0.
- R5: A page whose tag reads back wrong gets no map entry and uses no slot.
- R6: A double-bit error reported on a scan read skips that page without stopping the scan, even when it falls on the very last page scanned.
- R7: Every word of every mapped page reads 0 after the clearing pass. Pages that were not mapped are not written during that pass.
- R8: A double-bit error on a map-table read in the clearing pass sets fatal_o permanently. After that, no further request is made and done_o never rises.
- R9: Bank 0 pages 0 and 1 keep their contents (their tags 0 and 1 in word 0). Every word of bank 0 from offset 2*2^PAGE_W up to the end of the bank ends at 0.
- R10: done_o is high for exactly one cycle. page_cnt_o shows the number of mapped pages in that cycle, holds it while the block is idle, and returns to 0 when the next start is taken.
- R11: At most one request is outstanding at a time. While mem_req_o waits for mem_ack_i, its address, direction and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the sequence when idle |
| done_o | output | 1 | One-cycle completion pulse |
| fatal_o | output | 1 | Permanent halt after an uncorrectable error while clearing |
| page_cnt_o | output | OFS_W+1 | Number of virtual pages mapped |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_bank_o | output | 8 | Bank number of the access |
| mem_ofs_o | output | OFS_W | Word offset inside the bank |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | DW | Read data |
| mem_dbe_i | input | 1 | Uncorrectable error on this read |

## Verification
Two events can land on the same acknowledge. A scan read can return a double-bit error or a wrong tag on the final page before STOP_BANK, and in that same cycle the block must also decide to leave the scan. To provoke this, the error is injected on the highest installed page. In another run, the whole top bank is aliased onto the bank below it, so every late page fails its tag. The result is judged from storage and ports. The slot count must exclude the bad pages, the slot after the last good entry must still read VACANT, the clearing pass must still start and reach done, and the skipped page must keep its tag.

// File: rtl/bmi_pkg.sv
package bmi_pkg;
  localparam int BANK_W    = 8;
  localparam int BANK_FLD_W = 4;  // bank field in low bits of a map entry

  typedef enum logic [3:0] {
    ST_IDLE, ST_MARK, ST_VACATE, ST_MAP_RD, ST_MAP_WR,
    ST_CLR_RD, ST_CLR_WR, ST_ZERO0, ST_DONE, ST_HALT
  } bmi_state_e;
endpackage

// File: rtl/bmi_mem_if.sv
module bmi_mem_if
  import bmi_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int DW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              busy_o,
  output logic              resp_o,
  output logic [DW-1:0]     rdata_o,
  output logic              dbe_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic [OFS_W-1:0]  mem_ofs_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_dbe_i
);
  logic              req_q, we_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [DW-1:0]     wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      bank_q  <= '0;
      ofs_q   <= '0;
      wdata_q <= '0;
    end else if (!req_q && issue_i) begin
      req_q   <= 1'b1;
      we_q    <= we_i;
      bank_q  <= bank_i;
      ofs_q   <= ofs_i;
      wdata_q <= wdata_i;
    end else if (req_q && mem_ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign busy_o      = req_q;
  assign resp_o      = req_q & mem_ack_i;
  assign rdata_o     = mem_rdata_i;
  assign dbe_o       = mem_dbe_i;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_bank_o  = bank_q;
  assign mem_ofs_o   = ofs_q;
  assign mem_wdata_o = wdata_q;

  // R11
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !req_q);
  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !mem_ack_i) |=> (req_q && $stable(bank_q) && $stable(ofs_q)
                               && $stable(we_q) && $stable(wdata_q)));
endmodule

// File: rtl/bmi_ctrl.sv
module bmi_ctrl
  import bmi_pkg::*;
#(
  parameter int          OFS_W     = 16,
  parameter int          PAGE_W    = 8,
  parameter int          DW        = 16,
  parameter int          BANK_CNT  = 16,
  parameter int          STOP_BANK = 12,
  parameter int          IO_PAGE   = 64,
  parameter int          MAP_PAGES = 16,
  parameter logic [15:0] VACANT    = 16'h6000,
  parameter logic [15:0] PRESENT   = 16'h0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              resp_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic              dbe_i,
  output logic              issue_o,
  output logic              we_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [DW-1:0]     wdata_o,
  output logic              done_o,
  output logic              fatal_o,
  output logic [OFS_W:0]    cnt_o
);
  localparam int              PPB_W    = OFS_W - PAGE_W;
  localparam int              PG_W     = BANK_W + PPB_W;
  localparam int              MAP_N    = MAP_PAGES << PAGE_W;
  localparam logic [PG_W-1:0] PG_TOP   = PG_W'(BANK_CNT * (1 << PPB_W) - 1);
  localparam logic [PG_W-1:0] PG_SCAN0 = PG_W'((1 << PPB_W) + IO_PAGE);
  localparam logic [OFS_W:0]  MAP_LAST = (OFS_W+1)'(MAP_N - 1);
  localparam logic [OFS_W:0]  Z0_FIRST = (OFS_W+1)'(2 << PAGE_W);
  localparam logic [BANK_W-1:0] STOP_B = BANK_W'(STOP_BANK);
  localparam logic [BANK_W-1:0] BANK1  = BANK_W'(1);

  bmi_state_e             st_q;
  logic [PG_W-1:0]        pg_q;
  logic [OFS_W:0]         idx_q, slot_q, cnt_q;
  logic [PAGE_W-1:0]      wd_q;
  logic [BANK_FLD_W-1:0]  cb_q;   // bank of page being cleared
  logic [PPB_W-1:0]       cp_q;   // page within that bank

  logic [BANK_W-1:0] pg_bank;
  logic [OFS_W-1:0]  pg_ofs;
  logic              scan_end, tag_ok, access;

  assign pg_bank  = pg_q[PG_W-1:PPB_W];
  assign pg_ofs   = {pg_q[PPB_W-1:0], {PAGE_W{1'b0}}};
  assign scan_end = (&pg_q[PPB_W-1:0]) && (pg_bank + BANK1 == STOP_B);
  assign tag_ok   = !dbe_i && (rdata_i == DW'(pg_q));
  assign access   = st_q inside {ST_MARK, ST_VACATE, ST_MAP_RD, ST_MAP_WR,
                                 ST_CLR_RD, ST_CLR_WR, ST_ZERO0};
  assign issue_o  = access && !busy_i;
  assign done_o   = (st_q == ST_DONE);
  assign fatal_o  = (st_q == ST_HALT);
  assign cnt_o    = cnt_q;

  always_comb begin
    we_o    = 1'b1;
    bank_o  = '0;
    ofs_o   = '0;
    wdata_o = '0;
    unique case (st_q)
      ST_MARK: begin
        bank_o = pg_bank; ofs_o = pg_ofs; wdata_o = DW'(pg_q);
      end
      ST_VACATE: begin
        bank_o = BANK1; ofs_o = idx_q[OFS_W-1:0]; wdata_o = DW'(VACANT);
      end
      ST_MAP_RD: begin
        we_o = 1'b0; bank_o = pg_bank; ofs_o = pg_ofs;
      end
      ST_MAP_WR: begin
        bank_o  = BANK1; ofs_o = slot_q[OFS_W-1:0];
        wdata_o = DW'(pg_ofs) | DW'(pg_bank[BANK_FLD_W-1:0]) | DW'(PRESENT);
      end
      ST_CLR_RD: begin
        we_o = 1'b0; bank_o = BANK1; ofs_o = idx_q[OFS_W-1:0];
      end
      ST_CLR_WR: begin
        bank_o = BANK_W'(cb_q); ofs_o = {cp_q, wd_q};
      end
      ST_ZERO0: begin
        ofs_o = idx_q[OFS_W-1:0];
      end
      default: we_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; pg_q <= '0; idx_q <= '0; slot_q <= '0;
      cnt_q <= '0; wd_q <= '0; cb_q <= '0; cp_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_MARK; pg_q <= PG_TOP; slot_q <= '0; cnt_q <= '0;
        end
        ST_MARK: if (resp_i) begin
          if (pg_q == '0) begin st_q <= ST_VACATE; idx_q <= '0; end
          else pg_q <= pg_q - 1'b1;
        end
        ST_VACATE: if (resp_i) begin
          if (idx_q == MAP_LAST) begin st_q <= ST_MAP_RD; pg_q <= PG_SCAN0; end
          else idx_q <= idx_q + 1'b1;
        end
        ST_MAP_RD: if (resp_i) begin
          if (tag_ok) st_q <= ST_MAP_WR;
          else if (!scan_end) pg_q <= pg_q + 1'b1;
          else if (slot_q == '0) begin st_q <= ST_ZERO0; idx_q <= Z0_FIRST; end
          else begin st_q <= ST_CLR_RD; idx_q <= '0; end
        end
        ST_MAP_WR: if (resp_i) begin
          slot_q <= slot_q + 1'b1;
          if (scan_end) begin st_q <= ST_CLR_RD; idx_q <= '0; end
          else begin st_q <= ST_MAP_RD; pg_q <= pg_q + 1'b1; end
        end
        ST_CLR_RD: if (resp_i) begin
          if (dbe_i) st_q <= ST_HALT;
          else begin
            cb_q <= rdata_i[BANK_FLD_W-1:0];
            cp_q <= rdata_i[OFS_W-1:PAGE_W];
            wd_q <= '0;
            st_q <= ST_CLR_WR;
          end
        end
        ST_CLR_WR: if (resp_i) begin
          wd_q <= wd_q + 1'b1;
          if (&wd_q) begin
            if (idx_q + 1'b1 == slot_q) begin st_q <= ST_ZERO0; idx_q <= Z0_FIRST; end
            else begin st_q <= ST_CLR_RD; idx_q <= idx_q + 1'b1; end
          end
        end
        ST_ZERO0: if (resp_i) begin
          if (&idx_q[OFS_W-1:0]) begin st_q <= ST_DONE; cnt_q <= slot_q; end
          else idx_q <= idx_q + 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_HALT;
      endcase
    end
  end

  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  // R8
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> (!issue_o && !done_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !start_i) |=> $stable(cnt_o));
  // R4
  slot_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= (OFS_W+1)'(MAP_N));
  // R9
  bank0_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && bank_o == '0 && st_q != ST_MARK) |-> (ofs_o >= Z0_FIRST[OFS_W-1:0]));
endmodule

// File: rtl/boot_map_init.sv
module boot_map_init
  import bmi_pkg::*;
#(
  parameter int          OFS_W     = 16,
  parameter int          PAGE_W    = 8,
  parameter int          DW        = 16,
  parameter int          BANK_CNT  = 16,
  parameter int          STOP_BANK = 12,
  parameter int          IO_PAGE   = 64,
  parameter int          MAP_PAGES = 16,
  parameter logic [15:0] VACANT    = 16'h6000,
  parameter logic [15:0] PRESENT   = 16'h0080
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             done_o,
  output logic             fatal_o,
  output logic [OFS_W:0]   page_cnt_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [7:0]       mem_bank_o,
  output logic [OFS_W-1:0] mem_ofs_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_dbe_i
);
  logic              issue, we, busy, resp, dbe;
  logic [BANK_W-1:0] bank;
  logic [OFS_W-1:0]  ofs;
  logic [DW-1:0]     wdata, rdata;

  bmi_ctrl #(
    .OFS_W(OFS_W), .PAGE_W(PAGE_W), .DW(DW), .BANK_CNT(BANK_CNT),
    .STOP_BANK(STOP_BANK), .IO_PAGE(IO_PAGE), .MAP_PAGES(MAP_PAGES),
    .VACANT(VACANT), .PRESENT(PRESENT)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .busy_i(busy), .resp_i(resp), .rdata_i(rdata), .dbe_i(dbe),
    .issue_o(issue), .we_o(we), .bank_o(bank), .ofs_o(ofs), .wdata_o(wdata),
    .done_o, .fatal_o, .cnt_o(page_cnt_o)
  );

  bmi_mem_if #(.OFS_W(OFS_W), .DW(DW)) u_mem_if (
    .clk_i, .rst_ni,
    .issue_i(issue), .we_i(we), .bank_i(bank), .ofs_i(ofs), .wdata_i(wdata),
    .busy_o(busy), .resp_o(resp), .rdata_o(rdata), .dbe_o(dbe),
    .mem_req_o, .mem_we_o, .mem_bank_o, .mem_ofs_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i, .mem_dbe_i
  );
endmodule

// File: tb/boot_map_init_tb_top.sv
`timescale 1ns/1ps
module boot_map_init_tb_top;
  localparam int OFS_W = 8, PAGE_W = 5, DW = 16;
  localparam int BANKS = 4, STOP = 4, IOP = 2, MAPP = 1;
  localparam int WPP = 1 << PAGE_W, PPB = 1 << (OFS_W - PAGE_W);
  localparam int MAPN = MAPP * WPP;
  localparam int BSZ = 1 << OFS_W;
  localparam logic [15:0] VAC = 16'h6000, PRS = 16'h0010;
  localparam logic [15:0] FILL = 16'hA5A5;

  logic clk_i = 0, rst_ni = 0, start_i = 0;
  logic done_o, fatal_o, mem_req_o, mem_we_o, mem_ack_i = 0, mem_dbe_i = 0;
  logic [OFS_W:0] page_cnt_o;
  logic [7:0] mem_bank_o;
  logic [OFS_W-1:0] mem_ofs_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  boot_map_init #(
    .OFS_W(OFS_W), .PAGE_W(PAGE_W), .DW(DW), .BANK_CNT(BANKS),
    .STOP_BANK(STOP), .IO_PAGE(IOP), .MAP_PAGES(MAPP),
    .VACANT(VAC), .PRESENT(PRS)
  ) dut_i (.*);

  logic [15:0] mem [BANKS*BSZ];
  int lat = 0, dead_pg = -1, dbe_pg = -1, wcnt = 0;
  bit alias_en = 0, dbe_map = 0;
  int nchk = 0, nfail = 0, viol = 0;

  function automatic int phys(int b, int o);
    int bb = (alias_en && b == 3) ? 2 : b;
    if (bb >= BANKS) return -1;
    return bb * BSZ + o;
  endfunction

  // memory model, one access at a time
  always @(posedge clk_i) begin
    mem_ack_i <= 1'b0;
    if (mem_req_o && !mem_ack_i) begin
      if (wcnt >= lat) begin
        int pg, p;
        pg = int'(mem_bank_o) * PPB + (int'(mem_ofs_o) >> PAGE_W);
        p  = phys(int'(mem_bank_o), int'(mem_ofs_o));
        wcnt <= 0;
        mem_ack_i <= 1'b1;
        mem_dbe_i <= !mem_we_o && ((pg == dbe_pg) ||
                     (dbe_map && mem_bank_o == 8'd1 && int'(mem_ofs_o) < MAPN));
        if (mem_we_o) begin
          if (p >= 0 && pg != dead_pg) mem[p] <= mem_wdata_o;
        end else
          mem_rdata_i <= (p < 0) ? 16'hDEAD : (pg == dead_pg) ? 16'hBEEF : mem[p];
      end else wcnt <= wcnt + 1;
    end
  end

  // R11 request stability monitor
  logic pr_req = 0, pr_ack = 0, pr_we = 0;
  logic [7:0] pr_bank = '0;
  logic [OFS_W-1:0] pr_ofs = '0;
  logic [DW-1:0] pr_wd = '0;
  always @(negedge clk_i) begin
    if (pr_req && !pr_ack && (!mem_req_o || mem_bank_o != pr_bank ||
        mem_ofs_o != pr_ofs || mem_we_o != pr_we || mem_wdata_o != pr_wd))
      viol++;
    pr_req = mem_req_o; pr_ack = mem_ack_i; pr_we = mem_we_o;
    pr_bank = mem_bank_o; pr_ofs = mem_ofs_o; pr_wd = mem_wdata_o;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < BANKS*BSZ; i++) mem[i] = FILL;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    chk(page_cnt_o == '0, "R10 count cleared on start", int'(page_cnt_o), 0);
  endtask

  task automatic wait_end(output bit hit);
    int n = 0;
    while (!done_o && !fatal_o && n < 60000) begin @(negedge clk_i); n++; end
    hit = (n < 60000);
    if (!hit) chk(0, "watchdog", n, 0);
  endtask

  function automatic bit good(int pg);
    return !(pg == dead_pg || pg == dbe_pg || (alias_en && pg >= 3*PPB));
  endfunction

  task automatic run(input int l, input bit al, input int dd, input int db);
    bit hit, ok;
    int n, v, exp_map [MAPN];
    lat = l; alias_en = al; dead_pg = dd; dbe_pg = db; dbe_map = 0; viol = 0;
    fill();
    n = 0;
    for (int pg = PPB + IOP; pg < STOP*PPB; pg++)
      if (good(pg)) begin
        exp_map[n] = ((pg % PPB) << PAGE_W) | (pg / PPB) | int'(PRS);
        n++;
      end
    pulse_start();
    wait_end(hit);
    if (!hit) return;
    chk(done_o && !fatal_o, "R10 done without fatal", int'(fatal_o), 0);
    chk(int'(page_cnt_o) == n, "R10 page count", int'(page_cnt_o), n);
    @(negedge clk_i);
    chk(!done_o, "R10 done one cycle", int'(done_o), 0);
    repeat (5) @(negedge clk_i);
    chk(int'(page_cnt_o) == n, "R10 count held", int'(page_cnt_o), n);
    // map table
    for (int s = 0; s < MAPN; s++) begin
      v = int'(mem[BSZ + s]);
      if (s < n) chk(v == exp_map[s], "R4 map entry", v, exp_map[s]);
      else chk(v == int'(VAC), "R3 vacant slot", v, int'(VAC));
    end
    // scanned pages
    for (int pg = PPB + IOP; pg < STOP*PPB; pg++) begin
      int base = (pg / PPB) * BSZ + (pg % PPB) * WPP;
      if (alias_en && pg >= 3*PPB) continue;
      ok = 1;
      if (good(pg)) begin
        for (int w = 0; w < WPP; w++) if (mem[base+w] != 16'h0) ok = 0;
        chk(ok, "R7 mapped page zero", int'(mem[base]), 0);
      end else if (pg == dead_pg) begin
        for (int w = 0; w < WPP; w++) if (mem[base+w] != FILL) ok = 0;
        chk(ok, "R5 dead page untouched", int'(mem[base]), int'(FILL));
      end else begin
        chk(int'(mem[base]) == pg, "R6 dbe page skipped, tag kept", int'(mem[base]), pg);
        for (int w = 1; w < WPP; w++) if (mem[base+w] != FILL) ok = 0;
        chk(ok, "R7 unmapped page not cleared", int'(mem[base+1]), int'(FILL));
      end
    end
    // bank 0
    chk(mem[0] == 16'd0 && mem[1] == FILL, "R9 page0 kept", int'(mem[1]), int'(FILL));
    chk(mem[WPP] == 16'd1 && mem[WPP+1] == FILL, "R9 page1 kept", int'(mem[WPP]), 1);
    ok = 1;
    for (int i = 2*WPP; i < BSZ; i++) if (mem[i] != 16'h0) ok = 0;
    chk(ok, "R9 bank0 cleared from page 2", 0, 0);
    // tags of pages below the scan start in bank 1 above the map table
    chk(int'(mem[BSZ + WPP]) == PPB + 1, "R2 tag in bank1 page1",
        int'(mem[BSZ + WPP]), PPB + 1);
    chk(viol == 0, "R11 request stable until ack", viol, 0);
  endtask

  initial begin
    bit hit;
    fill();
    repeat (3) @(negedge clk_i);
    chk(!done_o && !fatal_o && !mem_req_o && page_cnt_o == '0, "R1 reset state",
        int'(mem_req_o), 0);
    rst_ni = 1;
    repeat (10) @(negedge clk_i);
    chk(!mem_req_o, "R1 idle without start", int'(mem_req_o), 0);

    run(0, 0, -1, -1);                 // clean memory
    run(2, 0, PPB + 4, STOP*PPB - 1);  // dead page, dbe on final scanned page
    run(1, 1, -1, PPB + IOP);          // top bank aliased; dbe on first page
    // R2: aliased top bank lost to the lower bank's tags
    chk(int'(page_cnt_o) == 2*PPB - IOP - 1, "R2 alias lower wins",
        int'(page_cnt_o), 2*PPB - IOP - 1);

    // R8: dbe on map-table read while clearing
    lat = 1; alias_en = 0; dead_pg = -1; dbe_pg = -1; dbe_map = 1; fill();
    pulse_start();
    wait_end(hit);
    if (hit) begin
      int bad = 0;
      chk(fatal_o && !done_o, "R8 fatal raised", int'(fatal_o), 1);
      repeat (3) @(negedge clk_i);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_i);
        if (!fatal_o || done_o || mem_req_o) bad++;
      end
      chk(bad == 0, "R8 halt permanent and quiet", bad, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule